// File: doc/BRIEF.md
# Load-and-Compare Controller

A state-only-output control unit that drives a two-register datapath. When the strobe `valid_i` is seen while the unit is at rest, it enables writes to both operand registers for exactly one cycle. It then spends one cycle holding, so that the registers present the values just written. After that it compares the two stored words and reports the result with a one-cycle completion pulse before it returns to rest.

The compare is never taken on the cycle that leaves the write state. On that edge the registers still hold the previous pair, and the completion pulse would describe stale operands. Every output is a function of the current state and the stored registers only. A parameter selects how the four states are coded in the state register: plain binary, reflected Gray or one-hot. Any code that matches no state falls back to rest on the next clock.

Top module: `ldcmp_ctrl`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `wr_a_o`, `wr_b_o`, `done_o`, `eq_o`, `gt_o` and `lt_o` are 0, and `a_o` and `b_o` are 0.
- R2: `valid_i` sampled high at rest raises `wr_a_o` and `wr_b_o` together for exactly the next cycle. The two enables are always equal.
- R3: The words on `a_i` and `b_i` during the write-enable cycle appear on `a_o` and `b_o` from the following cycle.
- R4: Exactly one cycle with both write enables and `done_o` low separates the write-enable cycle from the single `done_o` cycle. The unit is at rest in the cycle after `done_o`.
- R5: During `done_o`, exactly one of `eq_o` (A = B), `gt_o` (A > B) and `lt_o` (A < B) is high. The compare is unsigned and uses the newly written operands. Outside `done_o` all three flags are 0.
- R6: `valid_i` is ignored outside the rest state. If it is held high the whole time, a write-enable cycle occurs every 4 cycles.
- R7: Changes on `a_i` and `b_i` outside the write-enable cycle leave `a_o` and `b_o` unchanged.
- R8: Parameter `ENC` selects the state code: 0 gives binary rest/write/hold/compare = 00/01/10/11, 1 gives Gray 00/01/11/10, and 2 gives one-hot 0001/0010/0100/1000. The behaviour at the ports is identical for all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand-ready strobe |
| a_i | input | W | Operand A input |
| b_i | input | W | Operand B input |
| wr_a_o | output | 1 | Write enable of register A |
| wr_b_o | output | 1 | Write enable of register B |
| a_o | output | W | Stored operand A |
| b_o | output | W | Stored operand B |
| eq_o | output | 1 | A equals B, valid with done_o |
| gt_o | output | 1 | A greater than B, valid with done_o |
| lt_o | output | 1 | A less than B, valid with done_o |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench elaborates three copies side by side, with `ENC` set to 0, 1 and 2. All three receive the same stimulus and are checked against the same expectations, which covers all three state codings. The one-hot copy also enables a check that its state register never holds more than one set bit. A stale-operand scenario loads one pair and then a second pair whose compare result differs. In that scenario a compare taken one cycle early would report the wrong flag.

// File: rtl/ldcmp_pkg.sv
package ldcmp_pkg;
  typedef enum logic [1:0] {
    ST_REST  = 2'd0,
    ST_WRITE = 2'd1,
    ST_HOLD  = 2'd2,
    ST_CMP   = 2'd3
  } st_e;

  localparam int unsigned ENC_BIN    = 0;
  localparam int unsigned ENC_GRAY   = 1;
  localparam int unsigned ENC_ONEHOT = 2;

  function automatic int unsigned st_width(int unsigned enc);
    return (enc == ENC_ONEHOT) ? 4 : 2;
  endfunction

  function automatic logic [3:0] st_code(int unsigned enc, st_e s);
    logic [1:0] b;
    b = s;
    case (enc)
      ENC_GRAY:   return {2'b00, b ^ (b >> 1)};
      ENC_ONEHOT: return 4'b0001 << b;
      default:    return {2'b00, b};
    endcase
  endfunction
endpackage

// File: rtl/ldcmp_fsm.sv
module ldcmp_fsm
  import ldcmp_pkg::*;
#(
  parameter int unsigned ENC = ENC_BIN,
  localparam int unsigned SW = st_width(ENC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  output logic [SW-1:0] state_o,
  output logic          ld_o,
  output logic          cmp_o
);
  logic [SW-1:0] state_q, state_d;
  st_e           cur, nxt;

  // decode; unmatched codes read as rest
  always_comb begin
    cur = ST_REST;
    for (int i = 0; i < 4; i++) begin
      if (state_q == st_code(ENC, st_e'(i))[SW-1:0]) cur = st_e'(i);
    end
  end

  always_comb begin
    case (cur)
      ST_REST:  nxt = valid_i ? ST_WRITE : ST_REST;
      ST_WRITE: nxt = ST_HOLD;
      ST_HOLD:  nxt = ST_CMP;
      default:  nxt = ST_REST;
    endcase
    state_d = st_code(ENC, nxt)[SW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= st_code(ENC, ST_REST)[SW-1:0];
    else         state_q <= state_d;
  end

  assign ld_o    = (cur == ST_WRITE);
  assign cmp_o   = (cur == ST_CMP);
  assign state_o = state_q;
endmodule

// File: rtl/ldcmp_reg.sv
module ldcmp_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/ldcmp_cmp.sv
module ldcmp_cmp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         en_i,
  output logic         eq_o,
  output logic         gt_o,
  output logic         lt_o
);
  assign eq_o = en_i && (a_i == b_i);
  assign gt_o = en_i && (a_i >  b_i);
  assign lt_o = en_i && (a_i <  b_i);
endmodule

// File: rtl/ldcmp_ctrl.sv
module ldcmp_ctrl
  import ldcmp_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned ENC = ENC_BIN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         wr_a_o,
  output logic         wr_b_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         eq_o,
  output logic         gt_o,
  output logic         lt_o,
  output logic         done_o
);
  localparam int unsigned SW = st_width(ENC);

  logic [SW-1:0] state_q;
  logic          ld, cmp;

  ldcmp_fsm #(.ENC(ENC)) u_fsm (
    .clk_i, .rst_ni, .valid_i,
    .state_o(state_q), .ld_o(ld), .cmp_o(cmp)
  );

  ldcmp_reg #(.W(W)) u_reg_a (
    .clk_i, .rst_ni, .we_i(ld), .d_i(a_i), .q_o(a_o)
  );

  ldcmp_reg #(.W(W)) u_reg_b (
    .clk_i, .rst_ni, .we_i(ld), .d_i(b_i), .q_o(b_o)
  );

  ldcmp_cmp #(.W(W)) u_cmp (
    .a_i(a_o), .b_i(b_o), .en_i(cmp),
    .eq_o, .gt_o, .lt_o
  );

  assign wr_a_o = ld;
  assign wr_b_o = ld;
  assign done_o = cmp;
endmodule

// File: rtl/ldcmp_chk.sv
module ldcmp_chk #(
  parameter int unsigned W   = 8,
  parameter int unsigned ENC = 0,
  parameter int unsigned SW  = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic          wr_a_o,
  input logic          wr_b_o,
  input logic [W-1:0]  a_o,
  input logic [W-1:0]  b_o,
  input logic          eq_o,
  input logic          gt_o,
  input logic          lt_o,
  input logic          done_o,
  input logic [SW-1:0] state_i
);
  AST_WR_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_a_o == wr_b_o); // R2
  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_a_o |=> !wr_a_o); // R2
  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_a_o |=> (a_o == $past(a_i)) && (b_o == $past(b_i))); // R3
  AST_HOLD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_a_o |=> !done_o ##1 done_o); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o); // R4
  AST_FLAG_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot({eq_o, gt_o, lt_o})); // R5
  AST_FLAG_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ({eq_o, gt_o, lt_o} == 3'b000)); // R5
  AST_REG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_a_o |=> $stable(a_o) && $stable(b_o)); // R7
  AST_STATE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ENC == 2) |-> $onehot(state_i)); // R8
endmodule

bind ldcmp_ctrl ldcmp_chk #(.W(W), .ENC(ENC), .SW(SW)) u_chk (
  .clk_i, .rst_ni, .a_i, .b_i, .wr_a_o, .wr_b_o, .a_o, .b_o,
  .eq_o, .gt_o, .lt_o, .done_o, .state_i(state_q)
);

// File: tb/sim_ldcmp_ctrl.sv
module sim_ldcmp_ctrl;
  localparam int unsigned CLK_T = 10;
  localparam int unsigned W     = 8;
  localparam int unsigned N     = 3;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         wr_a [N], wr_b [N], eq [N], gt [N], lt [N], done [N];
  logic [W-1:0] a_q [N], b_q [N];
  int nchk = 0, nerr = 0;

  always #(CLK_T/2) clk = ~clk;

  ldcmp_ctrl #(.W(W), .ENC(0)) u0 (.clk_i(clk), .rst_ni, .valid_i(valid), .a_i(a_in), .b_i(b_in),
    .wr_a_o(wr_a[0]), .wr_b_o(wr_b[0]), .a_o(a_q[0]), .b_o(b_q[0]),
    .eq_o(eq[0]), .gt_o(gt[0]), .lt_o(lt[0]), .done_o(done[0]));
  ldcmp_ctrl #(.W(W), .ENC(1)) u1 (.clk_i(clk), .rst_ni, .valid_i(valid), .a_i(a_in), .b_i(b_in),
    .wr_a_o(wr_a[1]), .wr_b_o(wr_b[1]), .a_o(a_q[1]), .b_o(b_q[1]),
    .eq_o(eq[1]), .gt_o(gt[1]), .lt_o(lt[1]), .done_o(done[1]));
  ldcmp_ctrl #(.W(W), .ENC(2)) u2 (.clk_i(clk), .rst_ni, .valid_i(valid), .a_i(a_in), .b_i(b_in),
    .wr_a_o(wr_a[2]), .wr_b_o(wr_b[2]), .a_o(a_q[2]), .b_o(b_q[2]),
    .eq_o(eq[2]), .gt_o(gt[2]), .lt_o(lt[2]), .done_o(done[2]));

  task automatic chk(input string req, input int unsigned dut, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s enc=%0d act=%0h exp=%0h", req, dut, act, exp);
    end
  endtask

  // ctl = {wr_a, wr_b, done, eq, gt, lt}
  task automatic chk_all(input string req, input logic [5:0] ctl, input logic [W-1:0] ea, input logic [W-1:0] eb);
    for (int i = 0; i < N; i++) begin
      chk({req, " ctl"}, i, {26'd0, wr_a[i], wr_b[i], done[i], eq[i], gt[i], lt[i]}, {26'd0, ctl});
      chk({req, " a"}, i, {24'd0, a_q[i]}, {24'd0, ea});
      chk({req, " b"}, i, {24'd0, b_q[i]}, {24'd0, eb});
    end
  endtask

  function automatic logic [2:0] flags(input logic [W-1:0] a, input logic [W-1:0] b);
    return {a == b, a > b, a < b};
  endfunction

  task automatic t_reset();
    rst_ni = 1'b0; valid = 1'b1; a_in = 8'h5a; b_in = 8'ha5;
    repeat (3) @(negedge clk);
    chk_all("R1 in reset", 6'b0, '0, '0);
    valid = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk_all("R1 after reset", 6'b0, '0, '0);
  endtask

  // one load/compare pass; pa/pb are the previously stored values
  task automatic t_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] pa, input logic [W-1:0] pb);
    valid = 1'b1; a_in = a; b_in = b;
    @(negedge clk);
    chk_all("R2 write cycle", 6'b110000, pa, pb);
    valid = 1'b0;
    @(negedge clk);
    chk_all("R3 R4 hold cycle", 6'b000000, a, b);
    a_in = ~a; b_in = b ^ 8'h3c; // R7 noise outside write cycle
    @(negedge clk);
    chk_all("R5 compare cycle", {3'b001, flags(a, b)}, a, b);
    a_in = a + 8'd7;
    @(negedge clk);
    chk_all("R4 R7 back at rest", 6'b0, a, b);
  endtask

  task automatic t_stale();
    // second pair flips the result; an early compare would show the first
    t_op(8'h10, 8'h80, 8'h00, 8'h00);
    t_op(8'h80, 8'h10, 8'h10, 8'h80);
  endtask

  task automatic t_valid_held();
    valid = 1'b1; a_in = 8'h33; b_in = 8'h33;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      if (n % 4 == 0) chk_all("R6 periodic write", 6'b110000, (n == 0) ? 8'h80 : 8'h33, (n == 0) ? 8'h10 : 8'h33);
      else if (n % 4 == 2) chk_all("R6 periodic compare", 6'b001100, 8'h33, 8'h33);
      else chk_all("R6 valid ignored", 6'b0, 8'h33, 8'h33);
    end
    valid = 1'b0;
    @(negedge clk);
    chk_all("R6 rest after release", 6'b0, 8'h33, 8'h33);
  endtask

  initial begin
    t_reset();
    t_op(8'h12, 8'h12, 8'h00, 8'h00);   // eq
    t_op(8'hff, 8'h00, 8'h12, 8'h12);   // gt boundary, R8 across all encodings
    t_op(8'h00, 8'hff, 8'hff, 8'h00);   // lt boundary
    t_op(8'h7f, 8'h80, 8'h00, 8'hff);   // unsigned compare
    t_op(8'h00, 8'h00, 8'h7f, 8'h80);
    t_stale();
    t_valid_held();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(CLK_T * 20000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule